// File: doc/BRIEF.md
# Dual-Core Interrupt Doorbell

This block lets two processor cores signal each other through interrupts. Each core has a small pending-interrupt word of four flags. A core rings a doorbell on its partner by writing ones into the partner's set register. The partner acknowledges by writing ones into its own clear register. A core never writes a status word directly: the set and clear registers are its only path. Each status word drives one level-sensitive interrupt output toward the core that owns the word. The output stays high while any flag in that word is set.

The block sits on a simple 32-bit register bus with select, write, address, write data and read data. It decodes a 4 KB window. Every access is a full word, and a read returns its data in the same cycle. At the top of the window there is a fixed block of twelve read-only identification bytes. Reads and writes that do not match a legal register have no effect, and reads of such registers return zero.

Top module: `core_doorbell`

## Requirements
- R1: After reset both status words are zero and both interrupt outputs are low.
- R2: A write to the set register of core k (offset 0x10·k + 0x4) ORs write data bits [3:0] into that core's status word. Write data bits [31:4] are ignored.
- R3: A write to the clear register of core k (offset 0x10·k + 0x8) clears the status bits where write data bits [3:0] are one and leaves the other bits unchanged.
- R4: Interrupt output k is high exactly when status word k is nonzero. It changes one clock after the edge that changes the word.
- R5: A read of any set or clear register returns zero.
- R6: Writes to a status register (offset 0x10·k), to the identification block, or to an unmapped offset leave both status words and both interrupt outputs unchanged.
- R7: A read of an unmapped offset returns zero.
- R8: Reading offsets 0xFD0 to 0xFFC in 4-byte steps returns, in order, 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with the upper bits zero.
- R9: Address bits [1:0] and all address bits above bit 11 are not decoded. Any address aliases to the word at bits [11:2].
- R10: The two status words are independent. An access to one core's registers never changes the other core's word or interrupt output.
- R11: A read of status register k returns status word k in bits [3:0], with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; only bits [11:2] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq_out | output | 2 | Level interrupt per core, bit k driven from status word k |

## Verification
Set and clear writes are driven with data that carries ones above bit 3, which separates a correct 4-bit mask from a decoder that passes the upper bits through. Clear writes use partial masks, which separate a bitwise clear from a clear of the whole word. Set writes to a word that already holds flags tell an OR from an overwrite. Each interrupt output is sampled both in the cycle right after a write and one cycle later, which pins down its one-cycle lag. Writes to read-only and unmapped offsets, and to the other core's registers, are each followed by status readback to show nothing moved. Reads through addresses with stray low and high bits show the aliasing rule.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Register kinds produced by the address decoder.
  typedef enum logic [2:0] {
    RK_NONE   = 3'd0,
    RK_STATUS = 3'd1,
    RK_SET    = 3'd2,
    RK_CLEAR  = 3'd3,
    RK_IDENT  = 3'd4
  } reg_kind_e;

  // Word index of the first identification register (byte offset 0xFD0).
  localparam int unsigned IDENT_BASE_WORD = 10'h3F4;
  localparam int unsigned IDENT_COUNT     = 12;

  // Identification bytes, indexed from the lowest address upward.
  function automatic logic [7:0] ident_byte(input logic [3:0] idx);
    logic [7:0] v;
    case (idx)
      4'd0:    v = 8'h04;
      4'd4:    v = 8'h56;
      4'd5:    v = 8'hB8;
      4'd6:    v = 8'h0B;
      4'd8:    v = 8'h0D;
      4'd9:    v = 8'hF0;
      4'd10:   v = 8'h05;
      4'd11:   v = 8'hB1;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [9:0]        word_idx,
  output reg_kind_e         kind,
  output logic [CORE_W-1:0] core_sel,
  output logic [3:0]        ident_idx
);

  localparam int unsigned CORE_WORDS = NUM_CORES * 4;

  always_comb begin
    kind      = RK_NONE;
    core_sel  = word_idx[2 +: CORE_W];
    ident_idx = word_idx[3:0] - 4'd4;
    if (32'(word_idx) < CORE_WORDS) begin
      case (word_idx[1:0])
        2'd0:    kind = RK_STATUS;
        2'd1:    kind = RK_SET;
        2'd2:    kind = RK_CLEAR;
        default: kind = RK_NONE;
      endcase
    end else if (32'(word_idx) >= IDENT_BASE_WORD) begin
      kind = RK_IDENT;
    end
  end

endmodule

// File: rtl/doorbell_status.sv
module doorbell_status #(
  parameter int unsigned FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] bits,
  output logic [FLAG_W-1:0] word,
  output logic              irq
);

  logic [FLAG_W-1:0] word_nxt;

  always_comb begin
    word_nxt = word;
    if (set_en)      word_nxt = word | bits;
    else if (clr_en) word_nxt = word & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      irq  <= 1'b0;
    end else begin
      word <= word_nxt;
      irq  <= |word;
    end
  end

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(word));

  // R2
  set_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && (bits != '0)) |=> (word != '0));

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && (bits == '1)) |=> (word == '0));

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_en, 2));

endmodule

// File: rtl/core_doorbell.sv
module core_doorbell
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned FLAG_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CORES-1:0] irq_out
);

  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  reg_kind_e                         kind;
  logic [CORE_W-1:0]                 core_sel;
  logic [3:0]                        ident_idx;
  logic [NUM_CORES-1:0][FLAG_W-1:0]  status_w;
  logic                              wr_acc;
  logic                              rd_acc;
  logic                              unused_bits;

  assign wr_acc = bus_sel &&  bus_write;
  assign rd_acc = bus_sel && !bus_write;

  // Undecoded address bits and the masked-off data bits.
  assign unused_bits = ^{bus_addr[ADDR_W-1:12], bus_addr[1:0], bus_wdata[DATA_W-1:FLAG_W]};

  doorbell_decode #(.NUM_CORES(NUM_CORES)) u_decode (
    .word_idx  (bus_addr[11:2]),
    .kind      (kind),
    .core_sel  (core_sel),
    .ident_idx (ident_idx)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    logic hit;
    assign hit = wr_acc && (32'(core_sel) == k);

    doorbell_status #(.FLAG_W(FLAG_W)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (hit && (kind == RK_SET)),
      .clr_en (hit && (kind == RK_CLEAR)),
      .bits   (bus_wdata[FLAG_W-1:0]),
      .word   (status_w[k]),
      .irq    (irq_out[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (kind)
        RK_STATUS: bus_rdata = DATA_W'(status_w[core_sel]);
        RK_IDENT:  bus_rdata = DATA_W'(ident_byte(ident_idx));
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R5
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && ((kind == RK_SET) || (kind == RK_CLEAR))) |-> (bus_rdata == '0));

  // R6
  ro_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (kind != RK_SET) && (kind != RK_CLEAR)) |=> $stable(status_w));

  // R7
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_acc || (kind == RK_NONE)) |-> (bus_rdata == '0));

endmodule

// File: tb/core_doorbell_test.sv
`timescale 1ns/1ps
module core_doorbell_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  core_doorbell uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    #1;
    bus_sel = 1'b0;
  endtask

  task automatic expect_status(input string req, input logic [3:0] s0, input logic [3:0] s1);
    logic [31:0] d;
    bus_rd(32'h000, d); check(req, d, {28'd0, s0});
    bus_rd(32'h010, d); check(req, d, {28'd0, s1});
  endtask

  task automatic t_reset;
    check("R1 irq", {30'd0, irq_out}, 32'd0);
    expect_status("R1 status", 4'h0, 4'h0);
  endtask

  task automatic t_set_mask;
    bus_wr(32'h004, 32'hFFFF_FFF5);
    check("R4 irq lag", {30'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R4 irq high", {30'd0, irq_out}, 32'd1);
    expect_status("R2 mask / R10 other core / R11", 4'h5, 4'h0);
    bus_wr(32'h004, 32'h0000_0002);
    expect_status("R2 or", 4'h7, 4'h0);
  endtask

  task automatic t_clear;
    bus_wr(32'h008, 32'hFFFF_FF03);
    expect_status("R3 partial", 4'h4, 4'h0);
    check("R4 still high", {30'd0, irq_out}, 32'd1);
    bus_wr(32'h008, 32'hFFFF_FFFF);
    check("R4 fall lag", {30'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R4 low", {30'd0, irq_out}, 32'd0);
    expect_status("R3 all", 4'h0, 4'h0);
  endtask

  task automatic t_core1;
    bus_wr(32'h014, 32'h0000_000A);
    @(negedge clk);
    check("R10 irq1", {30'd0, irq_out}, 32'd2);
    bus_wr(32'h018, 32'h0000_0008);
    expect_status("R10 core1 / R3", 4'h0, 4'h2);
  endtask

  task automatic t_wo_read;
    logic [31:0] d;
    bus_wr(32'h004, 32'h0000_0009);
    bus_rd(32'h004, d); check("R5 set0", d, 32'd0);
    bus_rd(32'h008, d); check("R5 clr0", d, 32'd0);
    bus_rd(32'h014, d); check("R5 set1", d, 32'd0);
    bus_rd(32'h018, d); check("R5 clr1", d, 32'd0);
  endtask

  task automatic t_ro_write;
    bus_wr(32'h000, 32'h0000_0000);
    bus_wr(32'h010, 32'h0000_000F);
    bus_wr(32'hFD0, 32'hFFFF_FFFF);
    bus_wr(32'h00C, 32'h0000_000F);
    bus_wr(32'h020, 32'h0000_000F);
    bus_wr(32'h800, 32'h0000_000F);
    @(negedge clk);
    check("R6 irq", {30'd0, irq_out}, 32'd3);
    expect_status("R6 status", 4'h9, 4'h2);
  endtask

  task automatic t_unmapped_read;
    logic [31:0] d;
    bus_rd(32'h00C, d); check("R7 0x00C", d, 32'd0);
    bus_rd(32'h020, d); check("R7 0x020", d, 32'd0);
    bus_rd(32'h800, d); check("R7 0x800", d, 32'd0);
    bus_rd(32'hFCC, d); check("R7 0xFCC", d, 32'd0);
  endtask

  task automatic t_ident;
    logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                                8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [31:0] d;
    for (int i = 0; i < 12; i++) begin
      bus_rd(32'hFD0 + 32'(4 * i), d);
      check($sformatf("R8 id %0d", i), d, {24'd0, exp_id[i]});
    end
  endtask

  task automatic t_alias;
    logic [31:0] d;
    bus_wr(32'h008, 32'h0000_000F);
    bus_wr(32'h1000_0005, 32'h0000_0006);
    expect_status("R9 set alias", 4'h6, 4'h2);
    bus_rd(32'hABC0_0012, d); check("R9 status alias", d, 32'd2);
    bus_rd(32'hFFFF_FFF3, d); check("R9 id alias", d, 32'h0000_000D);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {30'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    expect_status("R1 status after reset", 4'h0, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_mask();
    t_clear();
    t_core1();
    t_wo_read();
    t_ro_write();
    t_unmapped_read();
    t_ident();
    t_alias();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule